// File: doc/BRIEF.md
# Immediate Register Load Unit

This unit keeps the processor's 16-bit immediate register and builds its contents from the short immediate field of an immediate-type instruction. That field is 15 bits wide, made of three 5-bit sections. A single load strobe turns the field into a full-width value in one of two ways. When the operand is an address, the field is shifted left one place and a zero is placed in bit 0, because every address is word-aligned. When the operand is data, the field is zero-extended, and a separate set-top-bit strobe can then supply the missing most significant bit.

The register's value is driven out continuously. The rest of the datapath reads it as general register 28, so every instruction other than the immediate load gets its constants through that register. The full instruction decoder, the ALU and memory access are outside this block. The decoder supplies the two strobes and the address/data flag.

Top module: `immreg_unit`

## Requirements
- R1: When `rst` is high at a rising clock edge, `imm_value` becomes 0x0000 after that edge. Reset takes priority over both strobes.
- R2: The immediate field is `instr_word[14:0]`, made of the sections [4:0], [9:5] and [14:10] in place. Bit 15 of the instruction never reaches the register.
- R3: A load with `addr_mode` = 1 writes `{instr_word[14:0], 1'b0}`, so bit 0 of the register is always 0 after an address load.
- R4: A load with `addr_mode` = 0 writes `{1'b0, instr_word[14:0]}`, which clears bit 15.
- R5: `set_msb` without `ld_imm` sets bit 15 and leaves bits 14:0 unchanged.
- R6: With neither strobe high, the register holds its value across any number of cycles.
- R7: If `ld_imm` and `set_msb` are both high in the same cycle, the load wins and `set_msb` has no effect.
- R8: A data load followed in the next cycle by `set_msb` gives the full 16-bit constant `{1'b1, field}`.
- R9: `instr_word` and `addr_mode` have no effect in any cycle where `ld_imm` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every update happens on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr_word | input | 16 | Instruction word; the low 15 bits form the immediate field |
| ld_imm | input | 1 | Load-immediate strobe |
| set_msb | input | 1 | Set-top-bit strobe |
| addr_mode | input | 1 | 1: expand the field as a word address; 0: expand it as data |
| imm_value | output | 16 | Current immediate register value (register 28) |

## Verification
The clocked properties assume that every input is a settled 0 or 1 at each rising edge, and that the strobes stay low while reset is asserted, except where reset priority is being tested. The assertions are disabled during reset, so that test does not depend on them. The bench changes inputs only on falling edges, gives every strobe and flag a defined value in every vector, and starts with a reset vector. It also sets instruction bit 15 in several loads to show that the bit is dropped.

// File: rtl/immreg_pkg.sv
package immreg_pkg;

   // Update selected for the immediate register in one cycle.
   typedef enum logic [1:0] {
      UPD_HOLD = 2'd0,
      UPD_LOAD = 2'd1,
      UPD_TOPB = 2'd2
   } upd_e;

endpackage

// File: rtl/immreg_field_slice.sv
module immreg_field_slice #(
   parameter int WORD_W = 16,
   parameter int SECT_W = 5,
   parameter int SECT_N = 3,
   localparam int FIELD_W = SECT_W * SECT_N
) (
   input  logic [WORD_W-1:0]  instr,
   output logic [FIELD_W-1:0] field
);

   if (FIELD_W >= WORD_W) begin : g_bad_field
      $error("immediate field must be narrower than the word");
   end

   // Copy each section into its place in the field.
   for (genvar s = 0; s < SECT_N; s++) begin : g_sect
      assign field[s*SECT_W +: SECT_W] = instr[s*SECT_W +: SECT_W];
   end

endmodule

// File: rtl/immreg_expand.sv
module immreg_expand #(
   parameter int WORD_W     = 16,
   parameter int FIELD_W    = 15,
   parameter int ALIGN_BITS = 1
) (
   input  logic [FIELD_W-1:0] field,
   input  logic               addr_mode,
   output logic [WORD_W-1:0]  value
);

   localparam int ADDR_SPAN = FIELD_W + ALIGN_BITS;

   if (ADDR_SPAN != WORD_W) begin : g_bad_span
      $error("field plus alignment bits must fill the word");
   end

   logic [WORD_W-1:0] addr_val;
   logic [WORD_W-1:0] data_val;

   if (ALIGN_BITS == 0) begin : g_no_align
      assign addr_val = field;
   end else begin : g_align
      assign addr_val = {field, {ALIGN_BITS{1'b0}}};
   end

   assign data_val = {{(WORD_W-FIELD_W){1'b0}}, field};
   assign value    = addr_mode ? addr_val : data_val;

endmodule

// File: rtl/immreg_update_sel.sv
module immreg_update_sel
   import immreg_pkg::*;
(
   input  logic ld_imm,
   input  logic set_msb,
   output upd_e upd
);

   // A load has priority over a set-top-bit request.
   always_comb begin
      if (ld_imm)       upd = UPD_LOAD;
      else if (set_msb) upd = UPD_TOPB;
      else              upd = UPD_HOLD;
   end

endmodule

// File: rtl/immreg_core.sv
module immreg_core
   import immreg_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  upd_e              upd,
   input  logic [WORD_W-1:0] load_val,
   output logic [WORD_W-1:0] q
);

   localparam int TOP = WORD_W - 1;

   if (WORD_W < 2) begin : g_bad_width
      $error("register must be at least two bits wide");
   end

   logic [WORD_W-1:0] nxt;

   // Only the top bit reacts to a set-top-bit request.
   for (genvar b = 0; b < WORD_W; b++) begin : g_bit
      if (b == TOP) begin : g_top
         always_comb begin
            unique case (upd)
               UPD_LOAD: nxt[b] = load_val[b];
               UPD_TOPB: nxt[b] = 1'b1;
               default:  nxt[b] = q[b];
            endcase
         end
      end else begin : g_low
         always_comb begin
            nxt[b] = (upd == UPD_LOAD) ? load_val[b] : q[b];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= nxt;
   end

endmodule

// File: rtl/immreg_unit.sv
module immreg_unit
   import immreg_pkg::*;
#(
   parameter int WORD_W     = 16,
   parameter int SECT_W     = 5,
   parameter int SECT_N     = 3,
   parameter int ALIGN_BITS = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [WORD_W-1:0] instr_word,
   input  logic              ld_imm,
   input  logic              set_msb,
   input  logic              addr_mode,
   output logic [WORD_W-1:0] imm_value
);

   localparam int FIELD_W = SECT_W * SECT_N;

   logic [FIELD_W-1:0] field;
   logic [WORD_W-1:0]  load_val;
   upd_e               upd;

   immreg_field_slice #(.WORD_W(WORD_W), .SECT_W(SECT_W), .SECT_N(SECT_N)) u_slice (
      .instr(instr_word),
      .field(field)
   );

   immreg_expand #(.WORD_W(WORD_W), .FIELD_W(FIELD_W), .ALIGN_BITS(ALIGN_BITS)) u_expand (
      .field    (field),
      .addr_mode(addr_mode),
      .value    (load_val)
   );

   immreg_update_sel u_sel (
      .ld_imm (ld_imm),
      .set_msb(set_msb),
      .upd    (upd)
   );

   immreg_core #(.WORD_W(WORD_W)) u_core (
      .clk     (clk),
      .rst     (rst),
      .upd     (upd),
      .load_val(load_val),
      .q       (imm_value)
   );

   // R3 address load: field shifted up, low bits zero
   a_r3_addr_load: assert property (@(posedge clk) disable iff (rst)
      (ld_imm && addr_mode) |=>
         imm_value == {$past(instr_word[FIELD_W-1:0]), {ALIGN_BITS{1'b0}}});

   // R4 data load: field zero-extended
   a_r4_data_load: assert property (@(posedge clk) disable iff (rst)
      (ld_imm && !addr_mode) |=>
         imm_value == WORD_W'($past(instr_word[FIELD_W-1:0])));

   // R5 set-top-bit keeps the low bits
   a_r5_top_set: assert property (@(posedge clk) disable iff (rst)
      (!ld_imm && set_msb) |=>
         (imm_value[WORD_W-1] &&
          imm_value[WORD_W-2:0] == $past(imm_value[WORD_W-2:0])));

   // R6 idle hold
   a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
      (!ld_imm && !set_msb) |=> $stable(imm_value));

   // R7 load wins over a simultaneous set-top-bit in data mode
   a_r7_load_wins: assert property (@(posedge clk) disable iff (rst)
      (ld_imm && set_msb && !addr_mode) |=> !imm_value[WORD_W-1]);

endmodule

// File: tb/tb_immreg_unit.sv
module tb_immreg_unit;

   logic        clk = 1'b0;
   logic        rst;
   logic [15:0] instr_word;
   logic        ld_imm, set_msb, addr_mode;
   logic [15:0] imm_value;

   int n_vec  = 0;
   int n_fail = 0;

   always #4 clk = ~clk;  // 125 MHz

   immreg_unit dut (
      .clk(clk), .rst(rst), .instr_word(instr_word), .ld_imm(ld_imm),
      .set_msb(set_msb), .addr_mode(addr_mode), .imm_value(imm_value)
   );

   // {rst, ld, msb, addr, instr[15:0], expected[15:0], req id}
   localparam int NV = 13;
   localparam logic [39:0] VEC [NV] = '{
      {1'b1,1'b0,1'b0,1'b0,16'hFFFF,16'h0000,4'd1},  // R1 reset
      {1'b0,1'b1,1'b0,1'b0,16'hFABC,16'h7ABC,4'd4},  // R4 data, bit15 of instr dropped (R2)
      {1'b0,1'b0,1'b1,1'b0,16'h0000,16'hFABC,4'd8},  // R8 set top bit next cycle
      {1'b0,1'b0,1'b0,1'b1,16'h1234,16'hFABC,4'd9},  // R9 idle, addr/instr ignored
      {1'b0,1'b1,1'b0,1'b1,16'h8123,16'h0246,4'd3},  // R3 address
      {1'b0,1'b1,1'b0,1'b1,16'h7FFF,16'hFFFE,4'd3},  // R3 address, bit0 zero
      {1'b0,1'b1,1'b1,1'b0,16'h0005,16'h0005,4'd7},  // R7 load wins (data)
      {1'b0,1'b1,1'b1,1'b1,16'h4000,16'h8000,4'd7},  // R7 load wins (address)
      {1'b0,1'b0,1'b1,1'b1,16'h0000,16'h8000,4'd5},  // R5 already set
      {1'b0,1'b1,1'b0,1'b0,16'h0000,16'h0000,4'd4},  // R4 clears bit15
      {1'b0,1'b0,1'b1,1'b0,16'hFFFF,16'h8000,4'd5},  // R5 low bits kept, instr ignored
      {1'b0,1'b0,1'b0,1'b0,16'hFFFF,16'h8000,4'd6},  // R6 hold
      {1'b1,1'b1,1'b1,1'b1,16'hFFFF,16'h0000,4'd1}   // R1 reset beats strobes
   };

   task automatic check(input string req, input logic [15:0] exp);
      n_vec++;
      if (imm_value !== exp) begin
         n_fail++;
         $display("FAIL %s: imm_value=%h expected=%h", req, imm_value, exp);
      end
   endtask

   task automatic drive(input logic r, input logic l, input logic m,
                        input logic a, input logic [15:0] iw);
      rst = r; ld_imm = l; set_msb = m; addr_mode = a; instr_word = iw;
      @(negedge clk);
   endtask

   initial begin
      rst = 1'b1; ld_imm = 1'b0; set_msb = 1'b0; addr_mode = 1'b0; instr_word = '0;
      @(negedge clk);
      @(negedge clk);
      check("R1", 16'h0000);

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i][39], VEC[i][38], VEC[i][37], VEC[i][36], VEC[i][35:20]);
         check($sformatf("R%0d", VEC[i][3:0]), VEC[i][19:4]);
      end

      // R8 full constant with all ones
      drive(1'b0, 1'b1, 1'b0, 1'b0, 16'h7FFF);
      check("R4", 16'h7FFF);
      drive(1'b0, 1'b0, 1'b1, 1'b0, 16'h0000);
      check("R8", 16'hFFFF);

      // R6 long hold with R9 noise on instr and addr_mode
      for (int k = 0; k < 20; k++) begin
         drive(1'b0, 1'b0, 1'b0, k[0], 16'(k * 16'h1357));
      end
      check("R6", 16'hFFFF);

      // R2 section placement: each 5-bit section lands in place
      drive(1'b0, 1'b1, 1'b0, 1'b0, 16'b1_10101_01010_10011);
      check("R2", 16'b0_10101_01010_10011);
      drive(1'b0, 1'b1, 1'b0, 1'b1, 16'b0_00001_00000_00001);
      check("R3", 16'b00001_00000_00001_0);

      // R1 reset mid-stream
      drive(1'b1, 1'b0, 1'b0, 1'b0, 16'h0000);
      check("R1", 16'h0000);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

endmodule